// File: doc/BRIEF.md
# Four-Source Fixed-Priority Interrupt Controller

This block collects interrupt requests from four sources and offers the processor one vector address. The sources are two external request pins, an overflow flag from the counter/timer and an overflow flag from the interval timer. Each external pin is active low and can be set to one of two modes. In level mode the request follows the pin. In edge mode a falling edge is caught in a flag, and the flag holds the request.

An enable byte supplies one enable bit per source and one global enable bit. Pending sources that are enabled are polled in a fixed order, and the highest one drives the vector output. There is only one interrupt level. Once the processor acknowledges a vector, an in-service bit blocks all further vectors until a return strobe arrives. On each acknowledge the block gives a one-cycle, one-hot pulse that names the source taken. The timer logic can use this pulse to clear its own overflow flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Among enabled pending sources the winner is chosen in fixed order, highest first: external 0 (source 0), counter/timer (source 1), external 1 (source 2), interval timer (source 3).
- R2: While `irq_req` is high, `irq_vec` holds the winner's address: 0x003 for source 0, 0x00B for source 1, 0x013 for source 2 and 0x01B for source 3. While `irq_req` is low, `irq_vec` is 0x000.
- R3: The enable byte gates each source: bit 0 gates source 0, bit 1 source 1, bit 2 source 2 and bit 3 source 3. Bit 7 is the global enable, and when it is 0 no request is offered. Bits 6 to 4 have no effect.
- R4: When an external channel is in edge mode (its mode input is 1), a high-to-low transition of the synchronized pin sets that channel's flag. The flag is the request and stays set after the pin returns high.
- R5: When an external channel is in level mode (its mode input is 0), the request is the inverted synchronized pin, with no latching. The channel's flag is held clear.
- R6: An acknowledge of an offered vector gives a one-cycle `taken` pulse with exactly the bit of the winning source set. If the winner is an edge-mode external source, the acknowledge also clears that source's flag.
- R7: An acknowledge sets `in_service`. While it is set, `irq_req` stays low whatever the sources do (no preemption). A `reti` strobe clears it at the next clock edge.
- R8: After reset, `irq_req` is low, `irq_vec` is 0, both flags are clear and `in_service` is low.
- R9: The timer overflow inputs are level requests that the controller does not clear. A timer request that is still asserted is offered again after `reti`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext0_n | input | 1 | External request pin 0, active low, asynchronous |
| ext1_n | input | 1 | External request pin 1, active low, asynchronous |
| ctr_ovf | input | 1 | Counter/timer overflow flag (source 1) |
| itmr_ovf | input | 1 | Interval timer overflow flag (source 3) |
| en_reg | input | 8 | Enable byte: bit 7 global, bits 3..0 per source |
| ext0_edge | input | 1 | Mode of channel 0: 1 edge, 0 level |
| ext1_edge | input | 1 | Mode of channel 1: 1 edge, 0 level |
| ack | input | 1 | Processor accepts the offered vector |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | A vector is offered |
| irq_vec | output | VEC_W | Vector address of the winning source |
| taken | output | 4 | One-hot pulse of the acknowledged source |
| ext0_flag | output | 1 | Edge flag of channel 0 |
| ext1_flag | output | 1 | Edge flag of channel 1 |
| in_service | output | 1 | An interrupt is being serviced |

## Verification
The bench builds the block with `SYNC_STAGES = 3` and `VEC_W = 11`. The deeper synchronizer makes the bench wait out a pin-to-flag delay longer than the default, and every check is placed after that delay. An 11-bit vector holds all five addresses with the upper bits seen as zero. Random trials draw values for the enable byte (reserved bits included), both modes, edge events, pin levels and timer flags. Each trial then follows the full request, acknowledge, block and return sequence. This brings priority ties, global masking, flag clearing and re-requests from still-pending timers within reach in a single run.

// File: rtl/irq_pkg.sv
// Package: shared constants and helpers for the interrupt controller.
// Assumes sources are numbered in polling order, 0 the highest.
package irq_pkg;
    localparam int NSRC       = 4;
    localparam int NEXT       = 2;
    localparam int GLOBAL_BIT = 7;

    // Source index of each external channel.
    function automatic int ext_src(input int ch);
        return ch * 2;
    endfunction

    // Vector address of a source: 3 plus 8 times its index.
    function automatic logic [15:0] vec_of(input int idx);
        return 16'(3 + 8 * idx);
    endfunction
endpackage

// File: rtl/irq_ext_chan.sv
// Module: one external request channel. It synchronizes an active-low
// pin, detects falling edges, keeps the edge flag and picks the level
// or edge request. Assumes SYNC_STAGES >= 2; the pin idles high.
module irq_ext_chan #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req,
    output logic flag
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pin_s;
    logic                   fall;

    assign pin_s = sync_q[SYNC_STAGES-1];
    assign fall  = prev_q & ~pin_s;

    // Purpose: bring the pin into the clock domain and keep its last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            prev_q <= pin_s;
        end
    end

    // Purpose: edge flag; a new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (!edge_mode) flag <= 1'b0;
        else if (fall)      flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end

    // Purpose: choose the request source by mode.
    always_comb req = edge_mode ? flag : ~pin_s;
endmodule

// File: rtl/irq_prio_arb.sv
// Module: masks the raw requests with the enables and grants the
// highest-priority one (lowest index). Grants nothing while blocked.
module irq_prio_arb
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] raw_req,
    input  logic [NSRC-1:0] src_en,
    input  logic            global_en,
    input  logic            blocked,
    output logic [NSRC-1:0] grant,
    output logic            any
);
    logic [NSRC-1:0] live;

    // Purpose: apply the per-source and global enables.
    always_comb live = raw_req & src_en & {NSRC{global_en & ~blocked}};

    // Purpose: fixed-priority pick, scanning from lowest to highest priority.
    always_comb begin
        grant = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (live[i]) grant = NSRC'(1) << i;
        end
    end

    assign any = |live;
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the four-source single-level interrupt controller.
// Builds two external channels, arbitrates, drives the vector and
// keeps the in-service bit. Assumes ack and reti are one-cycle strobes.
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext0_n,
    input  logic             ext1_n,
    input  logic             ctr_ovf,
    input  logic             itmr_ovf,
    input  logic [7:0]       en_reg,
    input  logic             ext0_edge,
    input  logic             ext1_edge,
    input  logic             ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [3:0]       taken,
    output logic             ext0_flag,
    output logic             ext1_flag,
    output logic             in_service
);
    logic [NEXT-1:0] pin_n_v, mode_v, req_v, flag_v;
    logic [NSRC-1:0] raw_req, grant;
    logic            any;
    logic            unused_rsvd;

    assign pin_n_v     = {ext1_n, ext0_n};
    assign mode_v      = {ext1_edge, ext0_edge};
    assign unused_rsvd = ^en_reg[6:4];

    // One channel per external pin.
    for (genvar c = 0; c < NEXT; c++) begin : g_ext
        irq_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (pin_n_v[c]),
            .edge_mode(mode_v[c]),
            .clr      (taken[ext_src(c)]),
            .req      (req_v[c]),
            .flag     (flag_v[c])
        );
    end

    // Purpose: place the requests in polling order.
    always_comb raw_req = {itmr_ovf, req_v[1], ctr_ovf, req_v[0]};

    irq_prio_arb u_arb (
        .raw_req  (raw_req),
        .src_en   (en_reg[NSRC-1:0]),
        .global_en(en_reg[GLOBAL_BIT]),
        .blocked  (in_service),
        .grant    (grant),
        .any      (any)
    );

    assign irq_req   = any;
    assign taken     = grant & {NSRC{ack & any}};
    assign ext0_flag = flag_v[0];
    assign ext1_flag = flag_v[1];

    // Purpose: map the one-hot grant to its vector address.
    always_comb begin
        irq_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) irq_vec = VEC_W'(vec_of(i));
        end
    end

    // Purpose: in-service bit, set on acknowledge, cleared by return.
    always_ff @(posedge clk) begin
        if (!rst_n)           in_service <= 1'b0;
        else if (reti)        in_service <= 1'b0;
        else if (ack && any)  in_service <= 1'b1;
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Module: assertion checker for irq_prio_ctrl, attached by bind.
module irq_prio_ctrl_chk #(
    parameter int VEC_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       en_reg,
    input logic             ext0_edge,
    input logic             ext1_edge,
    input logic             ack,
    input logic             reti,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic [3:0]       taken,
    input logic             ext0_flag,
    input logic             ext1_flag,
    input logic             in_service
);
    a_r6_taken_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken));
    a_r6_taken_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |-> $countones(taken) == 1);
    a_r7_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |-> !irq_req);
    a_r7_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && !reti) |=> in_service);
    a_r7_reti_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !in_service);
    a_r3_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !en_reg[7] |-> !irq_req);
    a_r2_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_vec == '0);
    a_r2_vec_valid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == VEC_W'(3) || irq_vec == VEC_W'(11) ||
                     irq_vec == VEC_W'(19) || irq_vec == VEC_W'(27)));
    a_r5_level_flag0: assert property (@(posedge clk) disable iff (!rst_n)
        !ext0_edge |=> !ext0_flag);
    a_r5_level_flag1: assert property (@(posedge clk) disable iff (!rst_n)
        !ext1_edge |=> !ext1_flag);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_reg    (en_reg),
    .ext0_edge (ext0_edge),
    .ext1_edge (ext1_edge),
    .ack       (ack),
    .reti      (reti),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .taken     (taken),
    .ext0_flag (ext0_flag),
    .ext1_flag (ext1_flag),
    .in_service(in_service)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
    localparam int SYNC  = 3;
    localparam int VW    = 11;
    localparam int WAITC = SYNC + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext0_n = 1'b1, ext1_n = 1'b1;
    logic          ctr_ovf = 1'b0, itmr_ovf = 1'b0;
    logic [7:0]    en_reg = 8'h00;
    logic          ext0_edge = 1'b0, ext1_edge = 1'b0;
    logic          ack = 1'b0, reti = 1'b0;
    logic          irq_req;
    logic [VW-1:0] irq_vec;
    logic [3:0]    taken;
    logic          ext0_flag, ext1_flag, in_service;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.SYNC_STAGES(SYNC), .VEC_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .ext0_n(ext0_n), .ext1_n(ext1_n),
        .ctr_ovf(ctr_ovf), .itmr_ovf(itmr_ovf), .en_reg(en_reg),
        .ext0_edge(ext0_edge), .ext1_edge(ext1_edge), .ack(ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .taken(taken),
        .ext0_flag(ext0_flag), .ext1_flag(ext1_flag), .in_service(in_service)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // Expected one-hot winner from requests and enable byte (R1, R3).
    function automatic logic [3:0] exp_grant(input logic [3:0] rq, input logic [7:0] en);
        logic [3:0] live;
        live = rq & en[3:0] & {4{en[7]}};
        for (int i = 0; i < 4; i++) if (live[i]) return 4'(1 << i);
        return 4'b0;
    endfunction

    // Expected vector for a grant (R2).
    function automatic logic [VW-1:0] exp_vec(input logic [3:0] g);
        for (int i = 0; i < 4; i++) if (g[i]) return VW'(3 + 8 * i);
        return '0;
    endfunction

    // One full request / acknowledge / return sequence.
    task automatic trial(input logic [7:0] en, input logic m0, input logic m1,
                         input logic e0, input logic e1, input logic l0, input logic l1,
                         input logic t0, input logic t1);
        logic [3:0] rq, g, g2;
        logic f0, f1;
        en_reg = 8'h00; ext0_edge = 0; ext1_edge = 0; ext0_n = 1; ext1_n = 1;
        ctr_ovf = 0; itmr_ovf = 0; reti = 1;
        tick(1);
        reti = 0;
        tick(WAITC);
        ext0_edge = m0; ext1_edge = m1;
        tick(2);
        if (m0 && e0) ext0_n = 0;
        if (m1 && e1) ext1_n = 0;
        tick(WAITC);
        if (m0) ext0_n = e0 ? l0 : 1'b1; else ext0_n = l0;
        if (m1) ext1_n = e1 ? l1 : 1'b1; else ext1_n = l1;
        ctr_ovf = t0; itmr_ovf = t1; en_reg = en;
        tick(WAITC);
        f0 = m0 & e0; f1 = m1 & e1;
        rq = {t1, m1 ? f1 : ~ext1_n, t0, m0 ? f0 : ~ext0_n};
        g  = exp_grant(rq, en);
        chk("R4/R5 flag0", 32'(ext0_flag), 32'(f0));
        chk("R4/R5 flag1", 32'(ext1_flag), 32'(f1));
        chk("R1/R3 irq_req", 32'(irq_req), 32'(g != 0));
        chk("R1/R2 irq_vec", 32'(irq_vec), 32'(exp_vec(g)));
        if (g != 0) begin
            ack = 1;
            #1;
            chk("R6 taken", 32'(taken), 32'(g));
            @(posedge clk); @(negedge clk);
            ack = 0;
            #1;
            chk("R7 in_service set", 32'(in_service), 32'd1);
            chk("R6 taken drops", 32'(taken), 32'd0);
            if (g[0]) begin f0 = 0; chk("R6 flag0 cleared", 32'(ext0_flag), 32'(f0)); end
            if (g[2]) begin f1 = 0; chk("R6 flag1 cleared", 32'(ext1_flag), 32'(f1)); end
            // No preemption even with everything requesting (R7).
            en_reg = 8'hFF; itmr_ovf = 1; ctr_ovf = 1;
            #1;
            chk("R7 no preempt req", 32'(irq_req), 32'd0);
            chk("R7 no preempt vec", 32'(irq_vec), 32'd0);
            en_reg = en; itmr_ovf = t1; ctr_ovf = t0;
            reti = 1;
            tick(1);
            reti = 0;
            #1;
            chk("R7 reti clears", 32'(in_service), 32'd0);
            rq = {t1, m1 ? f1 : ~ext1_n, t0, m0 ? f0 : ~ext0_n};
            g2 = exp_grant(rq, en);
            chk("R9 re-request", 32'(irq_req), 32'(g2 != 0));
            chk("R9 re-vector", 32'(irq_vec), 32'(exp_vec(g2)));
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        tick(3);
        // R8: reset state.
        chk("R8 req", 32'(irq_req), 32'd0);
        chk("R8 vec", 32'(irq_vec), 32'd0);
        chk("R8 flag0", 32'(ext0_flag), 32'd0);
        chk("R8 flag1", 32'(ext1_flag), 32'd0);
        chk("R8 in_service", 32'(in_service), 32'd0);
        rst_n = 1;
        tick(2);
        // R1: all four pending, all enabled -> source 0 wins.
        trial(8'h8F, 1, 1, 1, 1, 1, 1, 1, 1);
        // R3: reserved bits set but global off -> nothing.
        trial(8'h7F, 0, 0, 0, 0, 0, 0, 1, 1);
        // R3: reserved bits ignored with global on; only interval timer enabled.
        trial(8'hF8, 0, 0, 0, 0, 0, 0, 1, 1);
        // R4: edge on channel 1, pin back high, flag holds request.
        trial(8'h84, 0, 1, 0, 1, 1, 1, 0, 0);
        // R5: level mode, pin low then released -> request disappears.
        trial(8'h81, 0, 0, 0, 0, 0, 1, 0, 0);
        ext0_n = 1;
        tick(WAITC);
        chk("R5 level no latch req", 32'(irq_req), 32'd0);
        chk("R5 level flag clear", 32'(ext0_flag), 32'd0);
        // R9: timer stays pending across service.
        trial(8'h82, 0, 0, 0, 0, 1, 1, 1, 0);
        // Random trials.
        for (int k = 0; k < 300; k++) begin
            logic [9:0] r;
            r = 10'($urandom);
            trial(8'($urandom) | 8'(($urandom % 4 != 0) ? 8'h80 : 8'h00),
                  r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7]);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule